// File: doc/BRIEF.md
# Oscillator Clock Failure Supervisor

This block watches a reference oscillator clock and declares a failure when that clock stops producing rising edges for longer than a set window. The oscillator is treated as data. It passes through a synchronizer into the domain of a free-running backup clock, and a rising-edge detector follows. A counter on the backup clock measures the gap since the most recent edge. When the gap reaches the timeout threshold, the block flags a failure.

One control input chooses what a failure does. With self-clocking disabled, the block raises a reset request for a fixed number of backup-clock cycles. It does not raise the request again until the oscillator shows an edge. With self-clocking enabled, the block enters self-clock mode instead, and its mode output selects the fallback clock. The block leaves that mode only after a programmable count of consecutive good oscillator edges.

Every entry into or exit from self-clock mode sets a sticky change flag. Writing 1 to the clear input clears the flag, and an interrupt enable gates the flag onto the interrupt line.

Top module: `osc_fail_supervisor`

## Requirements
- R1: While `mon_en_i` is 0, `fail_o`, `rst_req_o` and `scm_o` stay 0, however long the oscillator stays stopped.
- R2: With monitoring enabled, `fail_o` rises when no rising oscillator edge has been seen for TIMEOUT backup cycles, plus at most a few cycles of synchronizer delay. While edges arrive at intervals well below TIMEOUT, `fail_o` stays 0.
- R3: When `self_clk_en_i` is 0, a failure produces one reset-request pulse exactly RST_CYC backup cycles long (RST_CYC is at least 4), and `scm_o` stays 0.
- R4: After a reset pulse, no further pulse is issued while the oscillator stays stopped. Once an oscillator edge is seen, a later failure issues a new pulse.
- R5: When `self_clk_en_i` is 1, a failure sets `scm_o` to 1, which selects the fallback clock, and no reset request is raised.
- R6: Self-clock mode ends on the rising edge that completes `good_edges_i` consecutive edges, each arriving within the timeout window of the one before. A value of 0 counts as 1. A gap that reaches the timeout restarts the count, and the edge that ends the gap counts as the first edge.
- R7: `scm_chg_o` is set to 1 on every change of `scm_o`, on entry and on exit alike.
- R8: A one-cycle pulse on `flag_clr_i` clears `scm_chg_o` to 0.
- R9: `irq_o` is 1 exactly when `scm_chg_o` and `irq_en_i` are both 1.
- R10: After reset, `fail_o`, `rst_req_o`, `scm_o`, `scm_chg_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running backup clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_clk_i | input | 1 | Oscillator clock under supervision, sampled as data |
| mon_en_i | input | 1 | Enables failure detection |
| self_clk_en_i | input | 1 | 1: a failure enters self-clock mode; 0: a failure requests a reset |
| good_edges_i | input | EDGE_W | Consecutive good edges required to leave self-clock mode (0 means 1) |
| irq_en_i | input | 1 | Interrupt enable for the change flag |
| flag_clr_i | input | 1 | Write-one-to-clear for the change flag |
| fail_o | output | 1 | Oscillator currently considered missing |
| rst_req_o | output | 1 | System reset request pulse |
| scm_o | output | 1 | Self-clock mode status; also selects the fallback clock |
| scm_chg_o | output | 1 | Sticky flag: `scm_o` has changed |
| irq_o | output | 1 | Interrupt request |

## Verification
A timeout counter that does not clear shows up as `fail_o` asserting while the oscillator is still toggling. One that clears too often shows up as `fail_o` failing to rise within the expected window after the oscillator stops. Both are visible within about TIMEOUT cycles. A faulty mode state shows up at once as a reset pulse of the wrong length, a second pulse with no intervening edge, or `scm_o` changing on the wrong edge of a hand-driven edge sequence. Errors in the flag and interrupt logic show up as `scm_chg_o` or `irq_o` disagreeing with the flag rules in the cycle after each change, clear or enable toggle.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_RST  = 2'd1,
    MODE_HOLD = 2'd2,
    MODE_SCM  = 2'd3
  } mode_e;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic edge_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], osc_i};
  end

  assign edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/osc_miss_timer.sv
module osc_miss_timer #(
  parameter int unsigned TIMEOUT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic edge_i,
  output logic miss_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || edge_i)   cnt_q <= '0;
    else if (cnt_q != LIM)      cnt_q <= cnt_q + 1'b1;
  end

  assign miss_o = en_i && (cnt_q == LIM);

  assert_miss_after_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_o) |-> !$past(edge_i));
endmodule

// File: rtl/osc_fail_ctrl.sv
module osc_fail_ctrl
  import osc_mon_pkg::*;
#(
  parameter int unsigned RST_CYC = 6,
  parameter int unsigned EDGE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic              edge_i,
  input  logic              self_clk_en_i,
  input  logic [EDGE_W-1:0] need_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  output logic              rst_req_o,
  output logic              scm_o,
  output logic              flag_o,
  output logic              irq_o
);
  localparam int unsigned RCW = $clog2(RST_CYC + 1);
  localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYC - 1);

  mode_e             mode_q, mode_d;
  logic [RCW-1:0]    rst_cnt_q, rst_cnt_d;
  logic [EDGE_W-1:0] good_q, good_d, good_inc, need_eff;
  logic              flag_q, flag_d, scm_chg;

  assign need_eff = (need_i == '0) ? EDGE_W'(1) : need_i;
  // an edge that ends a timed-out gap is the first of a new run
  assign good_inc = miss_i ? EDGE_W'(1) : good_q + 1'b1;

  always_comb begin
    mode_d    = mode_q;
    rst_cnt_d = rst_cnt_q;
    good_d    = good_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (miss_i) begin
          good_d = '0;
          if (self_clk_en_i) mode_d = MODE_SCM;
          else begin
            mode_d    = MODE_RST;
            rst_cnt_d = RST_LAST;
          end
        end
      end
      MODE_RST: begin
        if (rst_cnt_q == '0) mode_d = MODE_HOLD;
        else                 rst_cnt_d = rst_cnt_q - 1'b1;
      end
      MODE_HOLD: begin
        if (edge_i) mode_d = MODE_RUN;
      end
      MODE_SCM: begin
        if (edge_i) begin
          if (good_inc >= need_eff) begin
            mode_d = MODE_RUN;
            good_d = '0;
          end else begin
            good_d = good_inc;
          end
        end else if (miss_i) begin
          good_d = '0;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  assign scm_chg = (mode_d == MODE_SCM) != (mode_q == MODE_SCM);

  always_comb begin
    flag_d = flag_q;
    if (scm_chg)         flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN;
      rst_cnt_q <= '0;
      good_q    <= '0;
      flag_q    <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      rst_cnt_q <= rst_cnt_d;
      good_q    <= good_d;
      flag_q    <= flag_d;
    end
  end

  assign rst_req_o = (mode_q == MODE_RST);
  assign scm_o     = (mode_q == MODE_SCM);
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & irq_en_i;

  assert_rst_from_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(miss_i) && !$past(self_clk_en_i));

  assert_rst_min_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> $past(rst_req_o, 4));

  assert_scm_from_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scm_o) |-> $past(miss_i) && $past(self_clk_en_i));

  assert_scm_exit_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scm_o) |-> $past(edge_i));

  assert_flag_on_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scm_o != $past(scm_o)) |-> flag_o);

  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i));
endmodule

// File: rtl/osc_fail_supervisor.sv
module osc_fail_supervisor #(
  parameter int unsigned TIMEOUT     = 32,
  parameter int unsigned RST_CYC     = 6,
  parameter int unsigned EDGE_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_clk_i,
  input  logic              mon_en_i,
  input  logic              self_clk_en_i,
  input  logic [EDGE_W-1:0] good_edges_i,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  output logic              fail_o,
  output logic              rst_req_o,
  output logic              scm_o,
  output logic              scm_chg_o,
  output logic              irq_o
);
  logic osc_edge;
  logic miss;

  osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .osc_i  (osc_clk_i),
    .edge_o (osc_edge)
  );

  osc_miss_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mon_en_i),
    .edge_i (osc_edge),
    .miss_o (miss)
  );

  osc_fail_ctrl #(.RST_CYC(RST_CYC), .EDGE_W(EDGE_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .miss_i        (miss),
    .edge_i        (osc_edge),
    .self_clk_en_i (self_clk_en_i),
    .need_i        (good_edges_i),
    .flag_clr_i    (flag_clr_i),
    .irq_en_i      (irq_en_i),
    .rst_req_o     (rst_req_o),
    .scm_o         (scm_o),
    .flag_o        (scm_chg_o),
    .irq_o         (irq_o)
  );

  assign fail_o = miss;

  assert_no_fail_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_en_i && !$past(mon_en_i) |-> !rst_req_o || $past(rst_req_o));
endmodule

// File: tb/osc_fail_supervisor_tb.sv
module osc_fail_supervisor_tb;
  localparam int TIMEOUT = 32;
  localparam int RST_CYC = 6;
  localparam int EDGE_W  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic osc_gen = 1'b0, osc_man = 1'b0, osc_run = 1'b0;
  logic mon_en = 1'b0, self_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
  logic [EDGE_W-1:0] need = '0;
  logic fail, rst_req, scm, chg, irq;
  wire  osc_in = osc_gen ^ osc_man;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;
  always begin
    #40;
    if (osc_run) osc_gen = ~osc_gen;
    else         osc_gen = 1'b0;
  end

  osc_fail_supervisor #(.TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC), .EDGE_W(EDGE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .osc_clk_i(osc_in), .mon_en_i(mon_en),
    .self_clk_en_i(self_en), .good_edges_i(need), .irq_en_i(irq_en),
    .flag_clr_i(flag_clr), .fail_o(fail), .rst_req_o(rst_req), .scm_o(scm),
    .scm_chg_o(chg), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_edge();
    @(negedge clk) osc_man = 1'b1;
    cyc(5);
    osc_man = 1'b0;
    cyc(5);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    check(!fail && !rst_req && !scm && !chg && !irq, "R10", "outputs after reset",
          {fail, rst_req, scm, chg, irq}, 0);
  endtask

  task automatic t_running_ok();
    int seen = 0;
    osc_run = 1'b1; mon_en = 1'b1; self_en = 1'b0;
    cyc(20);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (fail || rst_req || scm) seen++;
    end
    check(seen == 0, "R2", "fail with oscillator toggling", seen, 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    mon_en = 1'b0;
    osc_run = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (fail || rst_req || scm) seen++;
    end
    check(seen == 0, "R1", "indication while monitor off", seen, 0);
    osc_run = 1'b1;
    cyc(20);
    mon_en = 1'b1;
    cyc(20);
  endtask

  task automatic t_reset_response();
    int n = 0, width = 0, extra = 0, scm_seen = 0;
    self_en = 1'b0;
    @(negedge clk) osc_run = 1'b0;
    while (!fail && n < 200) begin @(negedge clk); n++; end
    check(n >= TIMEOUT - 12 && n <= TIMEOUT + 6, "R2", "cycles from stop to fail",
          n, TIMEOUT);
    n = 0;
    while (!rst_req && n < 10) begin @(negedge clk); n++; end
    check(rst_req == 1'b1, "R3", "reset request raised", rst_req, 1);
    while (rst_req && width < 50) begin
      if (scm) scm_seen++;
      width++;
      @(negedge clk);
    end
    check(width == RST_CYC, "R3", "reset pulse width", width, RST_CYC);
    check(scm_seen == 0 && !scm, "R3", "scm during reset response", scm_seen, 0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rst_req) extra++;
    end
    check(extra == 0, "R4", "repeat pulse without edge", extra, 0);
    osc_run = 1'b1;
    cyc(40);
    check(!rst_req && !fail, "R4", "quiet after oscillator returns", {rst_req, fail}, 0);
    @(negedge clk) osc_run = 1'b0;
    n = 0;
    while (!rst_req && n < 200) begin @(negedge clk); n++; end
    check(rst_req == 1'b1, "R4", "new pulse after re-arm", rst_req, 1);
    osc_run = 1'b1;
    cyc(60);
  endtask

  task automatic t_scm_entry_and_flag();
    int n = 0, rst_seen = 0;
    self_en = 1'b1; irq_en = 1'b1; need = 4'd3;
    clear_flag();
    @(negedge clk) osc_run = 1'b0;
    while (!scm && n < 200) begin
      @(negedge clk); n++;
      if (rst_req) rst_seen++;
    end
    check(scm == 1'b1, "R5", "scm after failure", scm, 1);
    check(rst_seen == 0 && !rst_req, "R5", "reset request in scm path", rst_seen, 0);
    check(chg == 1'b1, "R7", "flag on scm entry", chg, 1);
    check(irq == 1'b1, "R9", "irq with flag and enable", irq, 1);
    @(negedge clk) irq_en = 1'b0;
    #1 check(irq == 1'b0, "R9", "irq with enable off", irq, 0);
    clear_flag();
    check(chg == 1'b0, "R8", "flag after clear", chg, 0);
    irq_en = 1'b1;
    #1 check(irq == 1'b0, "R9", "irq with flag clear", irq, 0);
  endtask

  task automatic t_scm_exit();
    pulse_edge();
    check(scm == 1'b1, "R6", "scm after edge 1 of 3", scm, 1);
    pulse_edge();
    check(scm == 1'b1, "R6", "scm after edge 2 of 3", scm, 1);
    cyc(50);
    check(scm == 1'b1 && !chg, "R6", "scm after long gap", {scm, chg}, 2);
    pulse_edge();
    check(scm == 1'b1, "R6", "gap restarts count, edge 1", scm, 1);
    pulse_edge();
    check(scm == 1'b1, "R6", "gap restarts count, edge 2", scm, 1);
    pulse_edge();
    osc_run = 1'b1;
    check(scm == 1'b0, "R6", "scm after third consecutive edge", scm, 0);
    check(chg == 1'b1, "R7", "flag on scm exit", chg, 1);
    check(irq == 1'b1, "R9", "irq on exit", irq, 1);
    cyc(40);
    check(scm == 1'b0 && !fail, "R6", "stays out with oscillator running", {scm, fail}, 0);
  endtask

  task automatic t_need_zero();
    int n = 0;
    clear_flag();
    need = '0;
    @(negedge clk) osc_run = 1'b0;
    while (!scm && n < 200) begin @(negedge clk); n++; end
    check(scm == 1'b1, "R5", "scm re-entry", scm, 1);
    pulse_edge();
    osc_run = 1'b1;
    check(scm == 1'b0, "R6", "need 0 exits on one edge", scm, 0);
    cyc(40);
  endtask

  initial begin
    cyc(5);
    rst_ni = 1'b1;
    cyc(2);
    t_reset_state();
    t_running_ok();
    t_disabled();
    t_reset_response();
    t_scm_entry_and_flag();
    t_scm_exit();
    t_need_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule